// File: doc/BRIEF.md
# Steerable Watchdog Countdown

This block is a watchdog timer that is controlled through one 8-bit configuration register. The register packs three fields. A 5-bit multiplier and a 2-bit resolution field set the timeout. A steering bit chooses what happens when the timeout runs out. The timeout is counted in strobes of an external 1/16-second tick, so a prescaler elsewhere in the chip sets the real-time unit.

Software keeps the watchdog alive by touching the register. A write restarts the countdown with the new setting. A read alone also restarts it, using the setting already held.

If the count runs out, the block raises a sticky expiry flag. It then takes one of two actions:
- It issues a one-cycle system reset request. It also clears its own configuration and sends a one-cycle request to a neighbouring register to clear its century bit.
- It issues a single one-cycle interrupt pulse.

Top module: `wdg_steer`

## Requirements
- R1: The timeout in ticks is N = mult × 4^res, where mult is register bits 6:2 and res is bits 1:0. After a restart, expiry happens on the Nth tick strobe accepted after the restart edge.
- R2: A write stores the byte in the register, which read data returns from the next cycle on, and restarts the countdown with the written setting.
- R3: A read restarts the countdown with the stored setting and does not change it.
- R4: Any restart (read or write) clears the expiry flag.
- R5: On expiry the expiry flag goes to 1 and stays there until the next restart.
- R6: With bit 7 set at expiry, the block pulses the reset request and the century-clear request together for exactly one cycle, and the register reads 0 afterwards.
- R7: With bit 7 clear at expiry, the block pulses the interrupt for exactly one cycle, with no reset request. The register keeps its value, and no further expiry happens without a new restart.
- R8: A register value whose timeout is zero (value 0, or multiplier 0 with any resolution) disables the watchdog: no expiry ever happens.
- R9: Without tick strobes the countdown holds, and resuming ticks continues from the held count.
- R10: After synchronous reset the register reads 0, the flag is 0 and no pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | 1/16-second strobe, one cycle wide |
| cfg_wr | input | 1 | Write strobe for the watchdog register |
| cfg_rd | input | 1 | Read strobe for the watchdog register (restarts the timer) |
| cfg_wdata | input | 8 | Write data: bit 7 steer, bits 6:2 multiplier, bits 1:0 resolution |
| cfg_rdata | output | 8 | Current register contents |
| wd_flag | output | 1 | Sticky expiry flag |
| sys_rst_req | output | 1 | One-cycle reset request on steered expiry |
| century_clr | output | 1 | One-cycle request to clear the neighbouring century bit |
| wd_irq | output | 1 | One-cycle interrupt on non-steered expiry |

## Verification
The hardest situation to reach from the ports is a read restart that lands partway through a running countdown. It must move the expiry to a later cycle without changing the setting.

To reach it, the stimulus first arms a short timeout with a write. A few cycles later, before that timeout runs out, it issues a read. It then withdraws the scoreboard entry for the first expiry and replaces it with one counted from the read.

Tick gating is reached in a similar way. The stimulus holds the strobe low across a long gap and then resumes it. The expected expiry cycle is then counted only from the resumed strobes.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    // Register layout: the steering bit is the MSB, the resolution field the LSBs
    localparam int MULT_W = 5;
    localparam int RES_W  = 2;
    localparam int REG_W  = 1 + MULT_W + RES_W;
    // Largest interval: mult_max << (2 * res_max)
    localparam int CNT_W  = MULT_W + 2 * ((1 << RES_W) - 1);

    typedef struct packed {
        logic              steer;
        logic [MULT_W-1:0] mult;
        logic [RES_W-1:0]  res;
    } wdg_cfg_t;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_IRQ   = 2'd1,
        ACT_RESET = 2'd2
    } wdg_act_e;

    // Decoded timeout in tick units: mult times four to the power res
    function automatic logic [CNT_W-1:0] wdg_interval(input wdg_cfg_t c);
        logic [CNT_W-1:0] m;
        m = CNT_W'(c.mult);
        return m << (2 * c.res);
    endfunction

endpackage

// File: rtl/wdg_cfg_reg.sv
module wdg_cfg_reg
    import wdg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr,
    input  wdg_cfg_t wdata,
    input  logic     clr,
    output wdg_cfg_t cfg
);

    // A write and a clear never meet: an expiry cannot happen in a restart cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr) begin
            cfg <= wdata;
        end else if (clr) begin
            cfg <= '0;
        end
    end

endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             expire
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;
    logic             armed;

    // Expiry is the Nth accepted tick; a restart in the same cycle takes priority
    assign expire = armed && tick && (cnt == ONE) && !restart;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (restart) begin
            cnt   <= load_val;
            armed <= (load_val != '0);
        end else if (armed && tick) begin
            if (cnt == ONE) begin
                armed <= 1'b0;
            end else begin
                cnt <= cnt - ONE;
            end
        end
    end

endmodule

// File: rtl/wdg_action.sv
module wdg_action
    import wdg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic expire,
    input  logic steer,
    output logic flag,
    output logic rst_req,
    output logic irq,
    output logic cent_clr
);

    wdg_act_e act;

    always_ff @(posedge clk) begin
        if (rst) begin
            act  <= ACT_NONE;
            flag <= 1'b0;
        end else begin
            if (expire) begin
                act <= steer ? ACT_RESET : ACT_IRQ;
            end else begin
                act <= ACT_NONE;
            end
            if (restart) begin
                flag <= 1'b0;
            end else if (expire) begin
                flag <= 1'b1;
            end
        end
    end

    assign rst_req  = (act == ACT_RESET);
    assign cent_clr = (act == ACT_RESET);
    assign irq      = (act == ACT_IRQ);

endmodule

// File: rtl/wdg_steer.sv
module wdg_steer
    import wdg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       cfg_wr,
    input  logic       cfg_rd,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    output logic       wd_flag,
    output logic       sys_rst_req,
    output logic       century_clr,
    output logic       wd_irq
);

    wdg_cfg_t         cfg_q;
    wdg_cfg_t         cfg_in;
    wdg_cfg_t         cfg_next;
    logic             restart;
    logic             expire;
    logic [CNT_W-1:0] load_val;

    assign cfg_in   = wdg_cfg_t'(cfg_wdata[REG_W-1:0]);
    assign restart  = cfg_wr || cfg_rd;
    // A write restarts with the new value, a read with the stored one
    assign cfg_next = cfg_wr ? cfg_in : cfg_q;
    assign load_val = wdg_interval(cfg_next);

    wdg_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr    (cfg_wr),
        .wdata (cfg_in),
        .clr   (expire && cfg_q.steer),
        .cfg   (cfg_q)
    );

    wdg_countdown #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .load_val (load_val),
        .tick     (tick),
        .expire   (expire)
    );

    wdg_action u_act (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .expire   (expire),
        .steer    (cfg_q.steer),
        .flag     (wd_flag),
        .rst_req  (sys_rst_req),
        .irq      (wd_irq),
        .cent_clr (century_clr)
    );

    assign cfg_rdata = cfg_q;

endmodule

// File: rtl/wdg_steer_chk.sv
module wdg_steer_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic       cfg_wr,
    input logic       cfg_rd,
    input logic [7:0] cfg_wdata,
    input logic [7:0] cfg_rdata,
    input logic       wd_flag,
    input logic       sys_rst_req,
    input logic       century_clr,
    input logic       wd_irq
);

    // R2: a write is visible on read data in the next cycle
    p_write_hold_r2: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> (cfg_rdata == $past(cfg_wdata)));

    // R4: a restart leaves the flag clear
    p_restart_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr || cfg_rd) |=> !wd_flag);

    // R5: every expiry action comes with the flag set
    p_flag_set_r5: assert property (@(posedge clk) disable iff (rst)
        (sys_rst_req || wd_irq) |-> wd_flag);

    // R6: the reset request lasts one cycle, the register is cleared, the century clear goes along
    p_rst_once_r6: assert property (@(posedge clk) disable iff (rst)
        sys_rst_req |=> !sys_rst_req);
    p_cfg_cleared_r6: assert property (@(posedge clk) disable iff (rst)
        sys_rst_req |-> (cfg_rdata == 8'h00));
    p_century_r6: assert property (@(posedge clk) disable iff (rst)
        sys_rst_req |-> century_clr);

    // R7: the interrupt lasts one cycle and never meets a reset request
    p_irq_once_r7: assert property (@(posedge clk) disable iff (rst)
        wd_irq |=> !wd_irq);
    p_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(wd_irq && sys_rst_req));

    // R9: with no tick and no restart, no expiry can follow
    p_no_tick_r9: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cfg_wr && !cfg_rd) |=> !(sys_rst_req || wd_irq));

endmodule

bind wdg_steer wdg_steer_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .cfg_wr      (cfg_wr),
    .cfg_rd      (cfg_rd),
    .cfg_wdata   (cfg_wdata),
    .cfg_rdata   (cfg_rdata),
    .wd_flag     (wd_flag),
    .sys_rst_req (sys_rst_req),
    .century_clr (century_clr),
    .wd_irq      (wd_irq)
);

// File: tb/wdg_steer_tb.sv
module wdg_steer_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       tick;
    logic       cfg_wr;
    logic       cfg_rd;
    logic [7:0] cfg_wdata;
    logic [7:0] cfg_rdata;
    logic       wd_flag;
    logic       sys_rst_req;
    logic       century_clr;
    logic       wd_irq;

    always #5 clk = ~clk;

    wdg_steer u_dut (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .cfg_wr      (cfg_wr),
        .cfg_rd      (cfg_rd),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .wd_flag     (wd_flag),
        .sys_rst_req (sys_rst_req),
        .century_clr (century_clr),
        .wd_irq      (wd_irq)
    );

    typedef struct {
        int cyc;
        bit is_rst;
    } exp_t;

    exp_t exp_q[$];
    int   ncyc    = 0;
    int   npulse  = 0;
    int   n_chk   = 0;
    int   n_fail  = 0;
    bit   mon_on  = 0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Monitor: pops the scoreboard when an expiry action appears
    always @(negedge clk) begin
        ncyc++;
        if (mon_on) begin
            if (sys_rst_req || wd_irq) begin
                npulse++;
                if (exp_q.size() == 0) begin
                    check(0, "R8 unexpected expiry", ncyc, -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(ncyc == e.cyc, "R1 expiry cycle", ncyc, e.cyc);
                    check(sys_rst_req == e.is_rst, "R6/R7 action kind", int'(sys_rst_req), int'(e.is_rst));
                    check(century_clr == sys_rst_req, "R6 century clear", int'(century_clr), int'(sys_rst_req));
                end
            end else if (exp_q.size() != 0 && exp_q[0].cyc < ncyc) begin
                exp_t e;
                e = exp_q.pop_front();
                check(0, "R1 missed expiry", ncyc, e.cyc);
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // Strobe for one cycle; returns the monitor count at drive time
    task automatic access(input bit is_wr, input logic [7:0] v, output int k);
        @(negedge clk);
        #1;
        cfg_wr    = is_wr;
        cfg_rd    = !is_wr;
        cfg_wdata = v;
        k         = ncyc;
        @(negedge clk);
        #1;
        cfg_wr = 1'b0;
        cfg_rd = 1'b0;
    endtask

    function automatic int ticks_of(input logic [7:0] v);
        return int'(v[6:2]) * (1 << (2 * int'(v[1:0])));
    endfunction

    // Driver: write and push the expected expiry
    task automatic wr_expect(input logic [7:0] v, output int k);
        exp_t e;
        access(1'b1, v, k);
        if (ticks_of(v) != 0) begin
            e.cyc    = k + 1 + ticks_of(v);
            e.is_rst = v[7];
            exp_q.push_back(e);
        end
    endtask

    bit done = 0;

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int k;
        int k2;
        int p0;
        rst = 1'b1; tick = 1'b1; cfg_wr = 1'b0; cfg_rd = 1'b0; cfg_wdata = '0;
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(1);
        mon_on = 1;

        // R10 reset state
        check(cfg_rdata == 8'h00, "R10 rdata", cfg_rdata, 0);
        check(wd_flag == 1'b0, "R10 flag", wd_flag, 0);
        wait_cyc(10);
        check(npulse == 0, "R10 no pulse", npulse, 0);

        // R1 R7: mult 3 res 0, interrupt steering
        wr_expect(8'h0C, k);
        check(cfg_rdata == 8'h0C, "R2 rdata after write", cfg_rdata, 8'h0C);
        wait_cyc(6);
        check(wd_flag == 1'b1, "R5 flag after expiry", wd_flag, 1);
        check(cfg_rdata == 8'h0C, "R7 register kept", cfg_rdata, 8'h0C);
        p0 = npulse;
        wait_cyc(20);
        check(npulse == p0, "R7 no re-expiry", npulse, p0);
        check(wd_flag == 1'b1, "R5 flag held", wd_flag, 1);

        // R6: steer, mult 2 res 1 -> 8 ticks
        wr_expect(8'h89, k);
        check(wd_flag == 1'b0, "R4 flag cleared by write", wd_flag, 0);
        wait_cyc(10);
        check(cfg_rdata == 8'h00, "R6 register cleared", cfg_rdata, 0);
        check(wd_flag == 1'b1, "R5 flag after reset", wd_flag, 1);

        // R3: read kick in the middle of a countdown
        wr_expect(8'h14, k);
        wait_cyc(1);
        access(1'b0, 8'h00, k2);
        void'(exp_q.pop_back());
        begin
            exp_t e;
            e.cyc = k2 + 1 + 5; e.is_rst = 1'b0;
            exp_q.push_back(e);
        end
        check(cfg_rdata == 8'h14, "R3 read keeps setting", cfg_rdata, 8'h14);
        wait_cyc(8);
        check(wd_flag == 1'b1, "R5 flag after kicked expiry", wd_flag, 1);
        access(1'b0, 8'h00, k2);
        begin
            exp_t e;
            e.cyc = k2 + 1 + 5; e.is_rst = 1'b0;
            exp_q.push_back(e);
        end
        check(wd_flag == 1'b0, "R4 flag cleared by read", wd_flag, 0);
        wait_cyc(8);

        // R8: zero value and zero multiplier disable
        p0 = npulse;
        wr_expect(8'h00, k);
        wait_cyc(40);
        check(npulse == p0, "R8 value zero disabled", npulse, p0);
        wr_expect(8'h83, k);
        wait_cyc(40);
        check(npulse == p0, "R8 mult zero disabled", npulse, p0);
        check(wd_flag == 1'b0, "R8 flag stays clear", wd_flag, 0);

        // R9: tick gating, mult 1 res 1 -> 4 ticks
        tick = 1'b0;
        access(1'b1, 8'h05, k);
        wait_cyc(20);
        check(npulse == p0, "R9 held without tick", npulse, p0);
        check(wd_flag == 1'b0, "R9 flag clear while held", wd_flag, 0);
        tick = 1'b1;
        begin
            exp_t e;
            e.cyc = ncyc + 4; e.is_rst = 1'b0;
            exp_q.push_back(e);
        end
        wait_cyc(8);

        // R1: larger intervals, 16 ticks and the maximum 1984 ticks
        wr_expect(8'h06, k);
        wait_cyc(20);
        wr_expect(8'hFF, k);
        wait_cyc(1990);
        check(cfg_rdata == 8'h00, "R6 cleared after long timeout", cfg_rdata, 0);
        check(exp_q.size() == 0, "R1 all expiries seen", exp_q.size(), 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule